// File: doc/BRIEF.md
# Global-History Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A shift register keeps the outcomes of the most recent branches. Its value is used directly as the address into a table of two-bit saturating counters. When the fetch stage presents a branch, the block returns a taken or not-taken guess in the same cycle. It also returns the history value it used. The pipeline carries that value along with the branch.

When the branch resolves, the pipeline returns the index, the real direction and a flag that says whether the guess was wrong. The counter at the returned index is then trained.

A parameter chooses when the history moves:
- **Speculative mode:** the guessed direction is shifted in at prediction time. A wrong guess rebuilds the history from the carried index with the correct direction appended.
- **Resolution mode:** only real outcomes are shifted in, at update time.

Top module: `gbp_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds 1, so the first lookup returns `pred_idx` = 0 and `pred_taken` = 0.
- R2: `pred_taken` is 1 exactly when the counter addressed by the current history holds 2 or 3; the counter is read before any update made in the same cycle takes effect.
- R3: `pred_idx` always equals the current history value, with the newest outcome in bit 0.
- R4: On `upd_valid`, the addressed counter moves up by one for a taken outcome and down by one for a not-taken outcome. It stays at 3 or 0 when already there.
- R5: The counter trained on `upd_valid` is the one at `upd_idx`, whatever the current history is.
- R6: With `SPEC_UPDATE`=1, each `pred_req` shifts the guessed direction (1 = taken) into bit 0 of the history and drops the oldest bit.
- R7: With `SPEC_UPDATE`=1, `upd_valid` with `upd_mispred` sets the history to `{upd_idx[HIST_W-2:0], upd_taken}`. This repair wins over a `pred_req` in the same cycle.
- R8: With `SPEC_UPDATE`=1, an update without `upd_mispred` leaves the history unchanged.
- R9: With `SPEC_UPDATE`=0, each `upd_valid` shifts `upd_taken` into bit 0 of the history. `pred_req` and `upd_mispred` have no effect on the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_req | input | 1 | A branch is being predicted this cycle |
| pred_taken | output | 1 | Guessed direction, 1 = taken |
| pred_idx | output | HIST_W | History value used for the guess |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_idx | input | HIST_W | Index captured when the branch was predicted |
| upd_mispred | input | 1 | The guess for this branch was wrong |

## Verification
Every cycle, the assertions check the history movement seen on `pred_idx`:
- the shift on prediction;
- the repair on a wrong guess and its priority;
- the hold on other cycles;
- the shift on resolution in the other mode;
- the cleared history after reset.

Counter saturation, training at a stale index, and the read-before-write order are not visible from one cycle's ports. Only the bench's sweeps can show them. The bench runs both modes side by side on a 4-bit history against arithmetic reference models.

// File: rtl/gbp_pkg.sv
// Shared types and helpers for the global-history predictor.
// Assumes counters are two bits wide; values 2 and 3 mean taken.
package gbp_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd1;
    localparam ctr_t CTR_MAX  = 2'd3;
    localparam ctr_t CTR_MIN  = 2'd0;

    // Saturating step of a counter toward the resolved direction.
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        if (taken)
            return (c == CTR_MAX) ? c : c + 2'd1;
        else
            return (c == CTR_MIN) ? c : c - 2'd1;
    endfunction

    // Taken guess when the counter's upper bit is set.
    function automatic logic ctr_taken(input ctr_t c);
        return c[1];
    endfunction
endpackage

// File: rtl/gbp_history.sv
// Global outcome history register.
// SPEC_UPDATE=1: shifts in the guess on each prediction and is
// rebuilt from the carried index on a wrong guess.
// SPEC_UPDATE=0: shifts in resolved outcomes only.
// Assumes HIST_W >= 2.
module gbp_history #(
    parameter int HIST_W      = 12,
    parameter bit SPEC_UPDATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_req,
    input  logic              pred_taken,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic              upd_mispred,
    input  logic [HIST_W-1:0] upd_idx,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_nxt;

    generate
        if (SPEC_UPDATE) begin : g_spec
            // Repair on a wrong guess beats the speculative shift.
            always_comb begin
                hist_nxt = hist;
                if (upd_valid && upd_mispred)
                    hist_nxt = {upd_idx[HIST_W-2:0], upd_taken};
                else if (pred_req)
                    hist_nxt = {hist[HIST_W-2:0], pred_taken};
            end
        end else begin : g_resolve
            // Only resolved outcomes move the history.
            always_comb begin
                hist_nxt = hist;
                if (upd_valid)
                    hist_nxt = {hist[HIST_W-2:0], upd_taken};
            end
        end
    endgenerate

    // Register the history; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else
            hist <= hist_nxt;
    end
endmodule

// File: rtl/gbp_table.sv
// Table of 2^HIST_W two-bit saturating counters.
// One asynchronous read port and one write port. A read in the
// same cycle as a write to the same entry returns the old value.
module gbp_table #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] rd_idx,
    output gbp_pkg::ctr_t     rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);
    import gbp_pkg::*;

    localparam int ENTRIES = 1 << HIST_W;

    ctr_t mem [ENTRIES];

    // Read the counter addressed by the history.
    always_comb rd_ctr = mem[rd_idx];

    // Reset all counters to weakly not-taken; train one entry per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                mem[i] <= CTR_INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
        end
    end
endmodule

// File: rtl/gbp_predictor.sv
// Top of the global-history direction predictor.
// The guess and its index are combinational from the current history.
// Counters train at resolution using the index carried with the branch.
// SPEC_UPDATE chooses speculative or resolution-time history movement.
module gbp_predictor #(
    parameter int HIST_W      = 12,
    parameter bit SPEC_UPDATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_req,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_idx,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_idx,
    input  logic              upd_mispred
);
    import gbp_pkg::*;

    logic [HIST_W-1:0] hist;
    ctr_t              cur_ctr;

    gbp_history #(.HIST_W(HIST_W), .SPEC_UPDATE(SPEC_UPDATE)) u_hist (
        .clk         (clk),
        .rst_n       (rst_n),
        .pred_req    (pred_req),
        .pred_taken  (pred_taken),
        .upd_valid   (upd_valid),
        .upd_taken   (upd_taken),
        .upd_mispred (upd_mispred),
        .upd_idx     (upd_idx),
        .hist        (hist)
    );

    gbp_table #(.HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (hist),
        .rd_ctr   (cur_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    // Drive the guess and the index snapshot.
    always_comb begin
        pred_taken = ctr_taken(cur_ctr);
        pred_idx   = hist;
    end
endmodule

// File: rtl/gbp_checker.sv
// Port-level checks of the history movement of gbp_predictor.
// Attached to every instance of the top module with a bind.
module gbp_checker #(
    parameter int HIST_W      = 12,
    parameter bit SPEC_UPDATE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pred_req,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_idx,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] upd_idx,
    input logic              upd_mispred
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pred_idx == '0 && !pred_taken)); // R1

    AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({pred_taken, pred_idx})); // R2

    generate
        if (SPEC_UPDATE) begin : g_spec
            AST_SPEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                (pred_req && !(upd_valid && upd_mispred)) |=>
                pred_idx == {$past(pred_idx[HIST_W-2:0]), $past(pred_taken)}); // R6

            AST_SPEC_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && upd_mispred) |=>
                pred_idx == {$past(upd_idx[HIST_W-2:0]), $past(upd_taken)}); // R7

            AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!pred_req && !(upd_valid && upd_mispred)) |=> $stable(pred_idx)); // R8
        end else begin : g_resolve
            AST_RES_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=>
                pred_idx == {$past(pred_idx[HIST_W-2:0]), $past(upd_taken)}); // R9

            AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_valid |=> $stable(pred_idx)); // R9
        end
    endgenerate
endmodule

bind gbp_predictor gbp_checker #(.HIST_W(HIST_W), .SPEC_UPDATE(SPEC_UPDATE)) u_chk (.*);

// File: tb/gbp_predictor_test.sv
// Runs both history modes side by side on a 4-bit history and
// compares them every cycle against arithmetic reference models.
module gbp_predictor_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 4;
    localparam int  N          = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_req = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0, upd_mispred = 1'b0;
    logic [W-1:0] upd_idx = '0;

    logic         s_taken, r_taken;
    logic [W-1:0] s_idx, r_idx;

    int checks = 0, fails = 0;

    int           s_cnt [N];
    int           r_cnt [N];
    logic [W-1:0] s_hist, r_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    gbp_predictor #(.HIST_W(W), .SPEC_UPDATE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_taken(s_taken),
        .pred_idx(s_idx), .upd_valid(upd_valid), .upd_taken(upd_taken),
        .upd_idx(upd_idx), .upd_mispred(upd_mispred));

    gbp_predictor #(.HIST_W(W), .SPEC_UPDATE(1'b0)) uut_res (
        .clk(clk), .rst_n(rst_n), .pred_req(pred_req), .pred_taken(r_taken),
        .pred_idx(r_idx), .upd_valid(upd_valid), .upd_taken(upd_taken),
        .upd_idx(upd_idx), .upd_mispred(upd_mispred));

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Compare both instances with their models; tag names the scenario.
    task automatic compare(input string tag);
        chk({tag, " R3 R6 R7 R8 spec index"}, s_idx, s_hist);
        chk({tag, " R2 R4 R5 spec guess"}, s_taken, (s_cnt[s_hist] >= 2) ? 1 : 0);
        chk({tag, " R3 R9 resolve index"}, r_idx, r_hist);
        chk({tag, " R2 R4 R5 resolve guess"}, r_taken, (r_cnt[r_hist] >= 2) ? 1 : 0);
    endtask

    // One cycle: drive at the falling edge, check, then advance the models.
    task automatic step(input logic pr, input logic uv, input logic ut,
                        input logic [W-1:0] ui, input logic um, input string tag);
        logic sg;
        @(negedge clk);
        pred_req = pr; upd_valid = uv; upd_taken = ut; upd_idx = ui; upd_mispred = um;
        #1;
        compare(tag);
        sg = (s_cnt[s_hist] >= 2);
        @(posedge clk);
        if (uv) begin
            s_cnt[ui] = ut ? ((s_cnt[ui] == 3) ? 3 : s_cnt[ui] + 1)
                           : ((s_cnt[ui] == 0) ? 0 : s_cnt[ui] - 1);
            r_cnt[ui] = ut ? ((r_cnt[ui] == 3) ? 3 : r_cnt[ui] + 1)
                           : ((r_cnt[ui] == 0) ? 0 : r_cnt[ui] - 1);
        end
        if (uv && um)   s_hist = {ui[W-2:0], ut};
        else if (pr)    s_hist = {s_hist[W-2:0], sg};
        if (uv)         r_hist = {r_hist[W-2:0], ut};
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < N; i++) begin s_cnt[i] = 1; r_cnt[i] = 1; end
        s_hist = '0;
        r_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state before any stimulus.
        #1;
        chk("R1 spec index", s_idx, 0);
        chk("R1 spec guess", s_taken, 0);
        chk("R1 resolve index", r_idx, 0);
        chk("R1 resolve guess", r_taken, 0);

        // R1 R7: repair the spec history to every value and read each initial counter.
        for (int i = 0; i < N; i++) begin
            step(1'b0, 1'b1, i[0], W'((i >> 1) | ((i & 1) << (W-1))), 1'b1, "R1 R7 sweep");
            step(1'b0, 1'b0, 1'b0, '0, 1'b0, "R1 R7 sweep read");
        end

        // R4: saturate upward, then downward, at the current spec history.
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b1, s_hist, 1'b0, "R4 up");
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0, s_hist, 1'b0, "R4 down");
        step(1'b0, 1'b1, 1'b1, s_hist, 1'b0, "R4 off floor");

        // R5: train a different entry; the current guess must not follow it.
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1, s_hist ^ W'(1), 1'b0, "R5 stale index");

        // R6 R9: predictions only; resolve history must hold, spec must shift.
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, '0, 1'b0, "R6 R9 predict only");

        // R7: repair and prediction in the same cycle; repair wins.
        step(1'b1, 1'b1, 1'b1, W'(5), 1'b1, "R7 priority");
        step(1'b1, 1'b1, 1'b0, W'(10), 1'b1, "R7 priority");

        // R8 R9: correct-guess updates; spec holds, resolve shifts, mispred flag ignored there.
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, k[0], W'(k), 1'b0, "R8 R9 update");
        step(1'b0, 1'b1, 1'b1, W'(3), 1'b1, "R9 mispred ignored");

        // Pseudo-random mixed traffic across all entries and both modes.
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1], lfsr[2], lfsr[7:4], lfsr[3] & lfsr[8], "R2 R4 R6 R7 R9 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule